// File: doc/BRIEF.md
# Block-Transfer Register Slave for a Two-Wire Management Bus

This block is a target on a two-wire management bus (SMBus/I2C style). It holds a small file of byte registers that a bus controller fills and reads back using block transfers. In every transfer the controller first names a starting register through a command byte. A length byte then travels with the data: the controller supplies it on writes, and the block reports it on reads. The block samples the clock and data lines with its own system clock. It pulls the data line low through an open-drain enable and never drives the line high.

A write is: start, address with the direction bit clear, command, length, data bytes, stop. The block acknowledges every byte it accepts and stores the data in consecutive registers. A read is: start, address for writing, command, repeated start, address with the direction bit set. The block then sends the length byte followed by register contents, until the controller answers a byte with a not-acknowledge. Bad addresses, bad commands and bad lengths are refused on the bus. After a refusal the block stays silent until the next start condition. Clock stretching, packet error codes and bus timeouts are not handled here.

Top module: `smb_blk_slave`

## Requirements
- R1: An address byte carries the target address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). The block acknowledges it only when bits 7:1 equal `DEV_ADDR`. On a mismatch it does not acknowledge and leaves SDA released for every later byte until the next start.
- R2: On a write, the block acknowledges the address, the command, the length and each data byte, including the last one. It stores data byte i in register (start + i).
- R3: A command byte of 00h starts the transfer at register 0.
- R4: Length values 1 to 32 are accepted, including 32. A length of 0 or above 32 is not acknowledged, and no register changes.
- R5: A command byte with bit 7 set is not acknowledged. The transfer is dropped and no register changes.
- R6: Data bytes beyond the announced length are not acknowledged and are not stored.
- R7: After the repeated start and a read address, the block first sends the length byte, which is min(`RD_COUNT`, 32). It then sends register data, most significant bit first, starting at the register selected by the command.
- R8: When the controller answers a sent byte with a not-acknowledge, the block releases SDA. It drives nothing more until the next start.
- R9: The start index is the command's low bits taken modulo `NUM_REGS`. The register pointer advances by one per data byte and wraps from `NUM_REGS`-1 to 0.
- R10: A stop in the middle of a byte returns the block to idle. A start in the middle of a byte returns it to the address phase. In both cases the partial byte is discarded and nothing is written.
- R11: The block changes its SDA drive only while SCL is low.
- R12: After reset, SDA is released and every register reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A corrupted bit counter or transfer state shows up at the next acknowledge slot of the same byte. The acknowledge appears in the wrong bit time or is missing, within nine SCL periods. A wrong register pointer or length counter cannot be seen during the write itself. It becomes visible in the following block read, as a byte at the wrong position or a stored byte that was meant to be refused. For that reason every write in the bench is followed by a read-back. A drive change while SCL is high would be seen by the bus as a false start or stop, and the bench watches for this on every cycle.

// File: rtl/smb_blk_pkg.sv
// Package: shared types and helpers for the block-transfer bus slave.
// Assumes byte-wide registers and an 8-bit length byte.
package smb_blk_pkg;

    localparam int unsigned BLK_MAX = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_CNT,
        ST_WDATA,
        ST_TX,
        ST_IGNORE
    } smb_state_t;

    // Length byte is legal when it lies in 1..BLK_MAX.
    function automatic logic blk_count_ok(input logic [7:0] c);
        return (c != 8'd0) && (c <= 8'(BLK_MAX));
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Module: brings SCL/SDA into the clock domain and flags bus events.
// Assumes STAGES >= 2 and that SCL stays low for several clocks per bit.
// Outputs are single-cycle pulses aligned to the synchronised lines.
module smb_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_s;
    logic              scl_d;
    logic              sda_d;

    // Shift both lines through the synchroniser chains; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Hold the previous synchronised values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Decode clock edges and data transitions under a high clock.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/smb_regfile.sv
// Module: byte register file with one write port and one combinational read.
// Assumes NUM_REGS is a power of two so any address is in range.
module smb_regfile #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 8,
    localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [NUM_REGS];

    // Clear all entries on reset, otherwise store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/smb_blk_slave.sv
// Module: bus target serving a register file through block transfers.
// Receives address, command, length and data bytes; on reads it sends the
// length and then register data. Assumes NUM_REGS is a power of two in
// 2..128, RD_COUNT >= 1, and a controller that never stretches or glitches
// the clock. Acknowledges are decided at the falling edge after bit 0.
module smb_blk_slave
    import smb_blk_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h2C,
    parameter int unsigned NUM_REGS    = 16,
    parameter int unsigned RD_COUNT    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int unsigned PTR_W  = $clog2(NUM_REGS);
    localparam int unsigned RD_CAP = (RD_COUNT > BLK_MAX) ? BLK_MAX : RD_COUNT;
    localparam logic [7:0]  RD_LEN = 8'(RD_CAP);

    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;

    smb_state_t       state;
    smb_state_t       next_q;
    smb_state_t       byte_next;
    logic [3:0]       bit_idx;
    logic             ack_slot;
    logic [7:0]       shreg;
    logic [PTR_W-1:0] ptr;
    logic [5:0]       rem_cnt;
    logic             mack;
    logic             rx_phase;
    logic             byte_done;
    logic             byte_ok;
    logic             wr_en;
    logic [7:0]       rd_data;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(8)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (shreg),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

    // Judge the completed byte for the current phase and choose the phase after its ACK slot.
    always_comb begin
        byte_ok   = 1'b0;
        byte_next = ST_IGNORE;
        case (state)
            ST_ADDR: begin
                byte_ok   = (shreg[7:1] == DEV_ADDR);
                byte_next = !byte_ok ? ST_IGNORE : (shreg[0] ? ST_TX : ST_CMD);
            end
            ST_CMD: begin
                byte_ok   = ~shreg[7];
                byte_next = byte_ok ? ST_CNT : ST_IGNORE;
            end
            ST_CNT: begin
                byte_ok   = blk_count_ok(shreg);
                byte_next = byte_ok ? ST_WDATA : ST_IGNORE;
            end
            ST_WDATA: begin
                byte_ok   = (rem_cnt != 6'd0);
                byte_next = byte_ok ? ST_WDATA : ST_IGNORE;
            end
            default: begin
                byte_ok   = 1'b0;
                byte_next = ST_IGNORE;
            end
        endcase
    end

    // Mark the receive phases, the end of a received byte and the register write strobe.
    always_comb begin
        rx_phase  = (state == ST_ADDR) || (state == ST_CMD) ||
                    (state == ST_CNT)  || (state == ST_WDATA);
        byte_done = rx_phase && scl_fall && (bit_idx == 4'd8) && !ack_slot;
        wr_en     = byte_done && (state == ST_WDATA) && byte_ok;
    end

    // Main transfer sequencer: bit shifting, ACK drive, pointer and length tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            next_q   <= ST_IDLE;
            bit_idx  <= 4'd0;
            ack_slot <= 1'b0;
            shreg    <= 8'd0;
            ptr      <= '0;
            rem_cnt  <= 6'd0;
            mack     <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            state    <= ST_ADDR;
            bit_idx  <= 4'd0;
            ack_slot <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            bit_idx  <= 4'd0;
            ack_slot <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_CMD, ST_CNT, ST_WDATA: begin
                    if (scl_rise && (bit_idx != 4'd8)) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_idx <= bit_idx + 4'd1;
                    end else if (byte_done) begin
                        ack_slot <= 1'b1;
                        sda_oe   <= byte_ok;
                        next_q   <= byte_next;
                        if ((state == ST_CMD) && byte_ok) begin
                            ptr <= shreg[PTR_W-1:0];
                        end
                        if ((state == ST_CNT) && byte_ok) begin
                            rem_cnt <= shreg[5:0];
                        end
                        if (wr_en) begin
                            ptr     <= ptr + PTR_W'(1);
                            rem_cnt <= rem_cnt - 6'd1;
                        end
                    end else if (scl_fall && ack_slot) begin
                        ack_slot <= 1'b0;
                        bit_idx  <= 4'd0;
                        state    <= next_q;
                        if (next_q == ST_TX) begin
                            shreg  <= RD_LEN;
                            sda_oe <= ~RD_LEN[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise && (bit_idx == 4'd8)) begin
                        mack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (bit_idx < 4'd7) begin
                            shreg   <= {shreg[6:0], 1'b0};
                            sda_oe  <= ~shreg[6];
                            bit_idx <= bit_idx + 4'd1;
                        end else if (bit_idx == 4'd7) begin
                            sda_oe  <= 1'b0;
                            bit_idx <= 4'd8;
                        end else if (mack) begin
                            shreg   <= rd_data;
                            sda_oe  <= ~rd_data[7];
                            ptr     <= ptr + PTR_W'(1);
                            bit_idx <= 4'd0;
                        end else begin
                            state  <= ST_IGNORE;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    // R11: the drive only moves in the cycle after the synchroniser saw SCL fall.
    p_drive_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(scl_fall));

    // R8: silent phases never pull the line.
    p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) || (state == ST_IGNORE)) |-> !sda_oe);

    // R10: a start or stop leaves the line released.
    p_release_on_cond_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_oe);

    // R9: each stored byte moves the pointer on by one, modulo the file size.
    p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == PTR_W'($past(ptr) + PTR_W'(1))));

    // R4: the data phase is only ever entered with a legal length.
    p_len_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA) |-> (rem_cnt <= 6'(BLK_MAX)));

endmodule

// File: tb/smb_blk_slave_tb.sv
module smb_blk_slave_tb;

    localparam logic [6:0] DEV  = 7'h2C;
    localparam int         NREG = 16;
    localparam int         RDC  = 8;
    localparam int         Q    = 8;

    // {command, length, first data value}
    localparam logic [23:0] VEC [5] = '{
        24'h00_03_11,
        24'h05_04_A0,
        24'h0E_05_40,
        24'h13_02_70,
        24'h08_20_C0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic tb_low = 1'b0;
    logic sda_oe;
    logic sda_bus;
    logic [7:0] model [NREG];
    int n_tests = 0;
    int n_fail = 0;
    int viol = 0;
    logic oe_prev = 1'b0;

    assign sda_bus = !(tb_low || sda_oe);

    always #2.5 clk = ~clk;

    smb_blk_slave #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .RD_COUNT(RDC), .SYNC_STAGES(2)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    // R11 monitor: the drive must not move while the bench holds SCL high.
    always @(negedge clk) begin
        if (rst_n && (sda_oe != oe_prev) && scl) viol = viol + 1;
        oe_prev = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        tb_low = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        tb_low = 1'b1; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        tb_low = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        tb_low = 1'b0; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            tb_low = !v[i]; tick(Q);
            scl = 1'b1; tick(2 * Q);
            scl = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        send_bits(v, 8);
        tb_low = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        ack = !sda_bus; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            tb_low = 1'b0; tick(Q);
            scl = 1'b1; tick(Q);
            v[i] = sda_bus; tick(Q);
            scl = 1'b0; tick(Q);
        end
        tb_low = give_ack; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
        tb_low = 1'b0;
    endtask

    task automatic expect_ack(input logic [7:0] v, input logic exp, input string tag);
        logic a;
        send_byte(v, a);
        check(a == exp, tag, {7'd0, a}, {7'd0, exp});
    endtask

    task automatic blk_write(input logic [7:0] cmd, input logic [7:0] cnt, input logic [7:0] seed, input string tag);
        bus_start();
        expect_ack({DEV, 1'b0}, 1'b1, tag);
        expect_ack(cmd, 1'b1, tag);
        expect_ack(cnt, 1'b1, tag);
        for (int i = 0; i < int'(cnt); i++) begin
            expect_ack(seed + 8'(i), 1'b1, tag);
            model[(int'(cmd) + i) % NREG] = seed + 8'(i);
        end
        bus_stop();
    endtask

    task automatic blk_read_check(input logic [7:0] cmd, input string tag);
        logic [7:0] v;
        bus_start();
        expect_ack({DEV, 1'b0}, 1'b1, tag);
        expect_ack(cmd, 1'b1, tag);
        bus_start();
        expect_ack({DEV, 1'b1}, 1'b1, tag);
        recv_byte(1'b1, v);
        check(v == 8'(RDC), "R7 length byte", v, 8'(RDC));
        for (int i = 0; i < RDC; i++) begin
            recv_byte(i != RDC - 1, v);
            check(v == model[(int'(cmd) + i) % NREG], tag, v, model[(int'(cmd) + i) % NREG]);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        string tag;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        tick(10);
        rst_n = 1'b1;
        tick(10);

        // R12: reset state at the ports and in the register file
        check(sda_oe == 1'b0, "R12 drive after reset", {7'd0, sda_oe}, 8'h00);
        check(sda_bus == 1'b1, "R12 line after reset", {7'd0, sda_bus}, 8'h01);
        blk_read_check(8'h00, "R12 reset contents");
        blk_read_check(8'h08, "R12 reset contents");

        // Vector table: block write then read-back
        for (int k = 0; k < 5; k++) begin
            tag = (k == 0) ? "R3 legacy command" : (k == 2) ? "R9 wrap" :
                  (k == 4) ? "R4 length 32" : "R2 block write";
            blk_write(VEC[k][23:16], VEC[k][15:8], VEC[k][7:0], tag);
            blk_read_check(VEC[k][23:16], "R7 read data");
        end

        // R1: foreign address refused, following bytes ignored
        bus_start();
        expect_ack({7'h23, 1'b0}, 1'b0, "R1 foreign address");
        expect_ack(8'h01, 1'b0, "R1 ignored byte");
        expect_ack(8'h01, 1'b0, "R1 ignored byte");
        expect_ack(8'hE1, 1'b0, "R1 ignored byte");
        bus_stop();
        blk_read_check(8'h01, "R1 contents kept");

        // R5: command with bit 7 set
        bus_start();
        expect_ack({DEV, 1'b0}, 1'b1, "R5 address");
        expect_ack(8'h85, 1'b0, "R5 bad command");
        expect_ack(8'h02, 1'b0, "R5 dropped");
        expect_ack(8'hEE, 1'b0, "R5 dropped");
        bus_stop();
        blk_read_check(8'h05, "R5 contents kept");

        // R4: illegal lengths 0 and 33
        bus_start();
        expect_ack({DEV, 1'b0}, 1'b1, "R4 address");
        expect_ack(8'h06, 1'b1, "R4 command");
        expect_ack(8'h00, 1'b0, "R4 length 0");
        bus_stop();
        bus_start();
        expect_ack({DEV, 1'b0}, 1'b1, "R4 address");
        expect_ack(8'h06, 1'b1, "R4 command");
        expect_ack(8'h21, 1'b0, "R4 length 33");
        expect_ack(8'h55, 1'b0, "R4 dropped data");
        bus_stop();
        blk_read_check(8'h06, "R4 contents kept");

        // R6: byte past the announced length
        bus_start();
        expect_ack({DEV, 1'b0}, 1'b1, "R6 address");
        expect_ack(8'h0A, 1'b1, "R6 command");
        expect_ack(8'h01, 1'b1, "R6 length");
        expect_ack(8'h5A, 1'b1, "R6 data");
        model[10] = 8'h5A;
        expect_ack(8'h77, 1'b0, "R6 extra byte");
        bus_stop();
        blk_read_check(8'h0A, "R6 contents");

        // R10: stop in the middle of a data byte
        bus_start();
        expect_ack({DEV, 1'b0}, 1'b1, "R10 address");
        expect_ack(8'h02, 1'b1, "R10 command");
        expect_ack(8'h02, 1'b1, "R10 length");
        expect_ack(8'h99, 1'b1, "R10 data");
        model[2] = 8'h99;
        send_bits(8'h33, 4);
        bus_stop();
        blk_read_check(8'h02, "R10 partial dropped");

        // R10: repeated start in the middle of a command byte
        bus_start();
        expect_ack({DEV, 1'b0}, 1'b1, "R10 address");
        send_bits(8'hFF, 5);
        bus_start();
        expect_ack({DEV, 1'b0}, 1'b1, "R10 address after restart");
        expect_ack(8'h0C, 1'b1, "R10 command");
        expect_ack(8'h01, 1'b1, "R10 length");
        expect_ack(8'h3C, 1'b1, "R10 data");
        model[12] = 8'h3C;
        bus_stop();
        blk_read_check(8'h0C, "R10 restart write");

        // R8: controller refuses the first data byte
        bus_start();
        expect_ack({DEV, 1'b0}, 1'b1, "R8 address");
        expect_ack(8'h00, 1'b1, "R8 command");
        bus_start();
        expect_ack({DEV, 1'b1}, 1'b1, "R8 read address");
        recv_byte(1'b1, v);
        check(v == 8'(RDC), "R7 length byte", v, 8'(RDC));
        recv_byte(1'b0, v);
        check(v == model[0], "R8 data", v, model[0]);
        check(sda_oe == 1'b0, "R8 released", {7'd0, sda_oe}, 8'h00);
        recv_byte(1'b0, v);
        check(v == 8'hFF, "R8 silent after refusal", v, 8'hFF);
        bus_stop();

        check(viol == 0, "R11 drive moves under high SCL", 8'(viol), 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule